// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs single management transactions towards an external Ethernet PHY over the two-wire MDC/MDIO serial interface (IEEE 802.3 Clause 22). A host writes a 16-bit data word and then a 16-bit command word. Accepting the command word starts a transaction. The controller produces MDC from the system clock, serializes the whole frame onto MDIO, and on reads releases the line so that the PHY can answer.

The host learns that a transaction has ended by polling one status bit in the command readback. That bit is high whenever the controller is idle. For a write, the value is taken from the data register, so the data word must be written before or together with the command word. For a read, the 16 bits returned by the PHY end up in the data register, ready when the status bit rises. While a transaction is running, the controller ignores further command or data writes.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command readback is 16'h8000, the data register is 0, MDC is low and MDIO is not driven. Whenever the finished bit (command bit 15) is high, MDC stays low and MDIO is released.
- R2: A command write while idle clears the finished bit in the next cycle. The finished bit rises again exactly 128*HALF_DIV cycles after the accepting clock edge.
- R3: MDC toggles every HALF_DIV system cycles while busy, which gives 64 MDC periods per frame. The default HALF_DIV of 40 gives 2.5 MHz from a 200 MHz clock.
- R4: Each frame carries, MSB first, 32 ones, then 01, then the opcode, then the PHY address from command bits 12:8, then the register address from bits 4:0, then the turnaround, then 16 data bits. The opcode is 01 when command bit 13 is set (write) and 10 when it is clear (read).
- R5: A write frame drives all 64 bits, with turnaround 10 and the data register contents. MDIO and its enable change only in the cycle where MDC falls, never while MDC is high.
- R6: A read frame releases MDIO from the first turnaround bit to the end of the frame. It samples mdio_i in each of the 16 data-bit cycles where MDC rises and shifts the bits into the data register MSB first.
- R7: A command write that arrives while busy has no effect. This includes the final cycle of a frame, the one in which the finished bit is about to rise.
- R8: A data write while busy has no effect. A data write and a command write in the same idle cycle send the new data value in the frame.
- R9: The command readback holds the finished bit in bit 15, the write flag in bit 13, the PHY address in 12:8 and the register address in 4:0. Bits 14 and 7:5 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Command word write strobe |
| ctl_wdata | input | 16 | Command word value |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register value |
| ctl_rdata | output | 16 | Command readback with finished bit |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from pad |

## Verification
Two functions can meet in one cycle. The first is a new command arriving in the very cycle in which the current frame ends. The bench counts 128*HALF_DIV cycles from the accepting edge and raises ctl_wr exactly on the completing edge. It then checks that the old command is still read back, that no MDC activity follows, and that a command one cycle later is accepted. The second is a data write and a command write landing in the same idle cycle. That case is judged by capturing the serialized frame at the MDC rising edges and requiring the newly written data in its last 16 bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;

  // Pull the meaningful fields out of a raw command word.
  function automatic mdio_cmd_t ctl_decode(input logic [12:0] w);
    mdio_cmd_t c;
    c.wr    = w[12];
    c.phy   = w[11:7];
    c.regad = w[4:0];
    return c;
  endfunction

  // Readback layout: finished, zero, write flag, phy, three zeros, register.
  function automatic logic [15:0] ctl_view(input mdio_cmd_t c, input logic fin);
    return {fin, 1'b0, c.wr, c.phy, 3'b000, c.regad};
  endfunction

  // Whole frame, first bit on the wire in the MSB.
  function automatic logic [FRAME_BITS-1:0] mdio_frame(input mdio_cmd_t c,
                                                       input logic [15:0] d);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] pay;
    op  = c.wr ? OP_WRITE : OP_READ;
    ta  = c.wr ? 2'b10 : 2'b11;
    pay = c.wr ? d : 16'hFFFF;
    return {{32{1'b1}}, SOF_CODE, op, c.phy, c.regad, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  logic tick;

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == CNT_LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CNT_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !run) mdc <= 1'b0;
    else if (tick) mdc <= ~mdc;
  end

  assign rise = tick & ~mdc;
  assign fall = tick & mdc;
endmodule

// File: rtl/mdio_frame_ser.sv
module mdio_frame_ser
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_wr,
  input  logic                  rise,
  input  logic                  fall,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  sample,
  output logic                  done
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sr;
  logic [CNT_W-1:0]      bitcnt;
  logic                  last_bit;

  assign last_bit = (bitcnt == LAST_IDX);
  assign done     = busy & fall & last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      sr     <= frame;
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (busy && fall) begin
      if (last_bit) begin
        busy <= 1'b0;
      end else begin
        sr     <= {sr[FRAME_BITS-2:0], 1'b0};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assign mdio_o  = sr[FRAME_BITS-1];
  assign mdio_oe = busy & (is_wr | (bitcnt < TA_IDX));
  assign sample  = busy & rise & ~is_wr & (bitcnt >= DAT_IDX);
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_wdata,
  input  logic        data_wr,
  input  logic [15:0] data_wdata,
  output logic [15:0] ctl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic busy_w, accept_w, sample_w, done_w, rise_w, fall_w;
  logic data_take_w;
  mdio_cmd_t cmd_q, cmd_new;
  logic [15:0] data_q, frame_data;
  logic [FRAME_BITS-1:0] frame_w;
  logic unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wdata[15:13], ctl_wdata[7:5]};

  assign cmd_new     = ctl_decode({ctl_wdata[13:8], 2'b00, ctl_wdata[4:0]});
  assign accept_w    = ctl_wr & ~busy_w;
  assign data_take_w = data_wr & ~busy_w;
  assign frame_data  = data_take_w ? data_wdata : data_q;
  assign frame_w     = mdio_frame(cmd_new, frame_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept_w) cmd_q <= cmd_new;
      if (data_take_w) data_q <= data_wdata;
      else if (sample_w) data_q <= {data_q[14:0], mdio_i};
    end
  end

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .mdc  (mdc),
    .rise (rise_w),
    .fall (fall_w)
  );

  mdio_frame_ser u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_w),
    .frame  (frame_w),
    .is_wr  (cmd_q.wr),
    .rise   (rise_w),
    .fall   (fall_w),
    .busy   (busy_w),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .sample (sample_w),
    .done   (done_w)
  );

  assign ctl_rdata  = ctl_view(cmd_q, ~busy_w);
  assign data_rdata = data_q;
endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        data_wr,
  input logic [15:0] ctl_rdata,
  input logic [15:0] data_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        sample_w,
  input logic        done_w
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[15] |-> (!mdc && !mdio_oe)); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_rdata[15]) |=> !ctl_rdata[15]); // R2

  AST_DONE_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> ctl_rdata[15]); // R2

  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_w |=> $rose(mdc)); // R6

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_w |-> !mdio_oe); // R6

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_rdata[15]) |=> $stable(ctl_rdata[13:0])); // R7

  AST_WRITE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[15] && ctl_rdata[13] && data_wr) |=> $stable(data_rdata)); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[14] == 1'b0) && (ctl_rdata[7:5] == 3'b000)); // R9
endmodule

bind mdio_cmd_ctrl mdio_cmd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .data_wr   (data_wr),
  .ctl_rdata (ctl_rdata),
  .data_rdata(data_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .sample_w  (sample_w),
  .done_w    (done_w)
);

// File: tb/test_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module test_mdio_cmd_ctrl;
  localparam int HD = 2;
  localparam int FRAME_CYC = 128 * HD;

  // vector: [26] write flag, [25:21] phy, [20:16] register, [15:0] data / PHY reply
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 5'd1,  5'd0,  16'h1234},
    {1'b0, 5'd1,  5'd1,  16'h796D},
    {1'b1, 5'd31, 5'd31, 16'hFFFF},
    {1'b0, 5'd16, 5'd2,  16'h8001},
    {1'b1, 5'd0,  5'd21, 16'h0000},
    {1'b0, 5'd10, 5'd30, 16'h5AA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic data_wr = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [15:0] ctl_rdata, data_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rises = 0;
  logic [63:0] cap = '0;
  logic [63:0] oe_cap = '0;
  logic [15:0] resp = '0;

  always #2.5 clk = ~clk;

  mdio_cmd_ctrl #(.HALF_DIV(HD)) i_mdio_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .ctl_rdata(ctl_rdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY side model: capture what is seen at each MDC rise, answer on falls.
  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_o};
    oe_cap = {oe_cap[62:0], mdio_oe};
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = resp[63 - rises];
    else mdio_i = 1'b1;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL R2 watchdog expired actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_data(input logic [15:0] d);
    @(negedge clk);
    data_wr = 1'b1; data_wdata = d;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic wait_done(output int len);
    len = 0;
    while (ctl_rdata[15] == 1'b0 && len < 4 * FRAME_CYC) begin
      @(negedge clk);
      len = len + 1;
    end
  endtask

  task automatic check_frame(input logic [15:0] w, input logic [15:0] d,
                             input string req);
    logic wr;
    logic [63:0] exp, mask;
    logic [15:0] view;
    wr = w[13];
    exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), w[12:8], w[4:0], 2'b10, d};
    mask = wr ? {64{1'b1}} : {{46{1'b1}}, {18{1'b0}}};
    view = {1'b1, 1'b0, wr, w[12:8], 3'b000, w[4:0]};
    chk((cap & mask) == (exp & mask), {req, " R4 frame bits"}, cap & mask, exp & mask);
    chk(oe_cap == mask, wr ? {req, " R5 drive enable"} : {req, " R6 release"},
        oe_cap, mask);
    chk(rises == 64, {req, " R3 mdc periods"}, rises, 64);
    chk(ctl_rdata == view, {req, " R9 readback"}, ctl_rdata, view);
    chk(data_rdata == d, wr ? {req, " R5 data kept"} : {req, " R6 read data"},
        data_rdata, d);
  endtask

  task automatic run_raw(input logic [15:0] w, input logic [15:0] d, input string req);
    int len;
    if (w[13]) pulse_data(d);
    resp = d;
    rises = 0;
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(ctl_rdata[15] == 1'b0, {req, " R2 busy after start"}, ctl_rdata[15], 0);
    wait_done(len);
    chk(len == FRAME_CYC, {req, " R2 frame length"}, len, FRAME_CYC);
    check_frame(w, d, req);
  endtask

  initial begin
    int len;
    logic [15:0] w_old, w_new;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 16'h8000, "R1 reset ctl", ctl_rdata, 16'h8000);
    chk(data_rdata == 16'h0000, "R1 reset data", data_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {mdc, mdio_oe}, 0);

    // table walk covering R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 6; i++) begin
      run_raw({2'b00, VEC[i][26], VEC[i][25:21], 3'b000, VEC[i][20:16]},
              VEC[i][15:0], $sformatf("vec%0d", i));
    end

    // R7 and R8: command and data writes in mid frame are ignored
    w_old = {2'b00, 1'b1, 5'd3, 3'b000, 5'd9};
    pulse_data(16'hA5C3);
    resp = 16'hA5C3;
    rises = 0;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w_old;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (60) @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {2'b00, 1'b0, 5'd31, 3'b000, 5'd31};
    data_wr = 1'b1; data_wdata = 16'hDEAD;
    @(negedge clk);
    ctl_wr = 1'b0; data_wr = 1'b0;
    chk(ctl_rdata[13:0] == w_old[13:0], "R7 busy cmd ignored", ctl_rdata, w_old);
    chk(data_rdata == 16'hA5C3, "R8 busy data ignored", data_rdata, 16'hA5C3);
    wait_done(len);
    check_frame(w_old, 16'hA5C3, "R7 mid");

    // R7 corner: command in the exact completing cycle is dropped
    w_old = {2'b00, 1'b0, 5'd5, 3'b000, 5'd2};
    w_new = {2'b00, 1'b1, 5'd7, 3'b000, 5'd7};
    resp = 16'h3C96;
    rises = 0;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w_old;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (FRAME_CYC - 1) @(negedge clk);
    chk(ctl_rdata[15] == 1'b0, "R2 still busy before last edge", ctl_rdata[15], 0);
    ctl_wr = 1'b1; ctl_wdata = w_new;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(ctl_rdata[15] == 1'b1, "R2 finished on schedule", ctl_rdata[15], 1);
    chk(ctl_rdata[13:0] == w_old[13:0], "R7 end-cycle cmd ignored", ctl_rdata, w_old);
    chk(data_rdata == 16'h3C96, "R6 read at end", data_rdata, 16'h3C96);
    repeat (10) @(negedge clk);
    chk(ctl_rdata[15] == 1'b1 && mdc == 1'b0 && rises == 64,
        "R7 no frame after dropped cmd", {ctl_rdata[15], mdc, rises[7:0]},
        {1'b1, 1'b0, 8'd64});
    run_raw(w_new, 16'h0F1E, "R7 next accepted");

    // R8 corner: data and command written in the same idle cycle
    w_old = {2'b00, 1'b1, 5'd2, 3'b000, 5'd4};
    rises = 0;
    resp = 16'hC3A9;
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = w_old;
    data_wr = 1'b1; data_wdata = 16'hC3A9;
    @(negedge clk);
    ctl_wr = 1'b0; data_wr = 1'b0;
    wait_done(len);
    check_frame(w_old, 16'hC3A9, "R8 same cycle");

    // R9: bits 15, 14 and 7:5 of the command word are dropped
    run_raw(16'hC0E0 | {2'b00, 1'b0, 5'd9, 3'b000, 5'd12}, 16'h4321, "R9 reserved");

    summary();
    $finish;
  end
endmodule